// File: doc/BRIEF.md
# Prescaled Down-Counter Timer Channel

This block is a single timer channel that counts down at the bus clock rate divided by a programmable prescaler. Software-side register writes reach it as one-cycle strobes with a shared data word. Separate strobes exist for an immediate reload value, a deferred reload value, the control byte and an interrupt clear. The channel presents its current count, stored reload value, control byte, raw and masked interrupt status and an interrupt line. Address decoding and merging several channels into one interrupt belong to the surrounding logic.

The count can run 16 bits wide, where the upper half is frozen and kept, or 32 bits wide. Width can change at run time without losing the frozen upper half. In free-running mode the count wraps to all ones. In periodic mode it reloads from the stored value, so a period lasts load+1 prescaled ticks. A one-shot option halts the count once it reaches zero.

Top module: `dctimer_chan`

## Requirements
- R1: The control byte maps one-shot to bit 0, width (1 = 32-bit) to bit 1, prescale code to bits 3:2, interrupt enable to bit 5, periodic mode to bit 6 and run enable to bit 7. Bit 4 and bits above 7 of a control write are dropped, and bit 4 reads as 0.
- R2: Prescale code 0 gives a tick every clock, code 1 every 16th clock and code 2 every 256th clock. Code 3 behaves like code 2. The divider restarts when the code changes or when enable rises, so the first tick lands 1, 16 or 256 clocks after the enabling write.
- R3: In 16-bit mode only bits 15:0 count and wrap, and bits 31:16 of the value hold their last contents. In 32-bit mode a decrement borrows across all 32 bits.
- R4: On the tick after the count is at zero, free-running mode loads all ones of the active width, and periodic mode loads the stored value (low half only in 16-bit mode).
- R5: With one-shot set, counting halts when the count reaches zero. A control write with enable set resumes it, and the next tick then wraps or reloads.
- R6: An immediate-load write sets both the stored value and the count. A deferred-load write sets only the stored value, which the count picks up at the next periodic reload.
- R7: In periodic mode, an immediate-load write whose active-width value is zero halts counting. A later non-zero immediate load resumes it.
- R8: Only a tick that decrements the count to zero sets the raw flag, never a wrap or reload. The flag stays set until a clear write.
- R9: The masked status and the interrupt line equal the raw flag ANDed with interrupt enable.
- R10: After reset the control byte is 0x20, the stored value is 0, the count is 0xFFFFFFFF and the raw flag is clear.
- R11: While enable is 0, the count only changes on an immediate-load write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_load | input | 1 | Immediate-load write strobe |
| wr_bgload | input | 1 | Deferred-load write strobe |
| wr_ctrl | input | 1 | Control write strobe |
| wr_intclr | input | 1 | Interrupt-clear write strobe |
| wdata | input | 32 | Write data |
| value_o | output | 32 | Current count |
| load_o | output | 32 | Stored reload value |
| ctrl_o | output | 8 | Control byte |
| ris_o | output | 1 | Raw interrupt flag |
| mis_o | output | 1 | Masked interrupt status |
| irq_o | output | 1 | Interrupt line |

## Verification
The properties assume the write strobes stay low during reset and that the immediate-load and deferred-load strobes never fire in the same cycle. The interrupt-clear check also takes it that no decrement-to-zero coincides with the clear, which is why it only looks at a halted channel. The bench issues each write as a lone one-cycle strobe between falling edges. It issues clears only while the count is away from one or the channel is disabled.

// File: rtl/dctimer_pkg.sv
package dctimer_pkg;

    localparam int CTRL_W = 8;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'd0,
        PS_DIV16  = 2'd1,
        PS_DIV256 = 2'd2,
        PS_RSVD   = 2'd3
    } presc_e;

    typedef struct packed {
        logic   en;
        logic   periodic;
        logic   ie;
        logic   unused4;
        presc_e presc;
        logic   wide;
        logic   oneshot;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{en: 1'b0, periodic: 1'b0, ie: 1'b1, unused4: 1'b0,
                                   presc: PS_DIV1, wide: 1'b0, oneshot: 1'b0};

    function automatic ctrl_t ctrl_clean(input logic [CTRL_W-1:0] raw);
        ctrl_t c;
        c = ctrl_t'(raw);
        c.unused4 = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/dctimer_presc.sv
module dctimer_presc
    import dctimer_pkg::*;
#(
    parameter int MID_LOG = 4,
    parameter int HI_LOG  = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   active,
    input  logic   restart,
    input  presc_e presc,
    output logic   tick
);
    logic [HI_LOG-1:0] pcnt_q;
    logic mid_hit, hi_hit;

    assign mid_hit = &pcnt_q[MID_LOG-1:0];
    assign hi_hit  = &pcnt_q;

    always_comb begin
        unique case (presc)
            PS_DIV1:  tick = active;
            PS_DIV16: tick = active && mid_hit;
            default:  tick = active && hi_hit;   // code 3 follows code 2
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || restart) pcnt_q <= '0;
        else if (active)    pcnt_q <= pcnt_q + 1'b1;
    end
endmodule

// File: rtl/dctimer_count.sv
module dctimer_count #(
    parameter int CNT_W  = 32,
    parameter int HALF_W = CNT_W / 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wide,
    input  logic             periodic,
    input  logic             oneshot,
    input  logic [CNT_W-1:0] reload,
    input  logic             wr_load,
    input  logic [CNT_W-1:0] wdata,
    input  logic             go,
    input  logic             intclr,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             ris
);
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic run_q, ris_q;
    logic at_zero, at_one, wd_zero;

    always_comb begin
        if (wide) begin
            at_zero = (cnt_q == '0);
            at_one  = (cnt_q == CNT_W'(1));
            wd_zero = (wdata == '0);
        end else begin
            at_zero = (cnt_q[HALF_W-1:0] == '0);
            at_one  = (cnt_q[HALF_W-1:0] == HALF_W'(1));
            wd_zero = (wdata[HALF_W-1:0] == '0);
        end
    end

    always_comb begin
        if (at_zero) begin
            if (periodic)
                cnt_nxt = wide ? reload : {cnt_q[CNT_W-1:HALF_W], reload[HALF_W-1:0]};
            else
                cnt_nxt = wide ? '1 : {cnt_q[CNT_W-1:HALF_W], {HALF_W{1'b1}}};
        end else begin
            cnt_nxt = wide ? cnt_q - CNT_W'(1)
                           : {cnt_q[CNT_W-1:HALF_W], cnt_q[HALF_W-1:0] - HALF_W'(1)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '1;
            run_q <= 1'b1;
            ris_q <= 1'b0;
        end else begin
            if (wr_load)   cnt_q <= wdata;
            else if (tick) cnt_q <= cnt_nxt;

            if (wr_load && periodic)         run_q <= !wd_zero;
            else if (go)                     run_q <= 1'b1;
            else if (tick && at_one && oneshot) run_q <= 1'b0;

            if (tick && at_one) ris_q <= 1'b1;
            else if (intclr)    ris_q <= 1'b0;
        end
    end

    assign cnt = cnt_q;
    assign run = run_q;
    assign ris = ris_q;
endmodule

// File: rtl/dctimer_chan.sv
module dctimer_chan
    import dctimer_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int MID_LOG = 4,
    parameter int HI_LOG  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_load,
    input  logic              wr_bgload,
    input  logic              wr_ctrl,
    input  logic              wr_intclr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  value_o,
    output logic [CNT_W-1:0]  load_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              ris_o,
    output logic              mis_o,
    output logic              irq_o
);
    localparam int HALF_W = CNT_W / 2;

    ctrl_t ctrl_q, ctrl_new;
    logic [CNT_W-1:0] load_q;
    logic restart, go, run, tick, ris;

    assign ctrl_new = ctrl_clean(wdata[CTRL_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
            load_q <= '0;
        end else begin
            if (wr_ctrl)              ctrl_q <= ctrl_new;
            if (wr_load || wr_bgload) load_q <= wdata;
        end
    end

    assign restart = wr_ctrl && ((ctrl_new.presc != ctrl_q.presc) || (ctrl_new.en && !ctrl_q.en));
    assign go      = wr_ctrl && ctrl_new.en;

    dctimer_presc #(.MID_LOG(MID_LOG), .HI_LOG(HI_LOG)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .active  (ctrl_q.en && run),
        .restart (restart),
        .presc   (ctrl_q.presc),
        .tick    (tick)
    );

    dctimer_count #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .wide     (ctrl_q.wide),
        .periodic (ctrl_q.periodic),
        .oneshot  (ctrl_q.oneshot),
        .reload   (load_q),
        .wr_load  (wr_load),
        .wdata    (wdata),
        .go       (go),
        .intclr   (wr_intclr),
        .cnt      (value_o),
        .run      (run),
        .ris      (ris)
    );

    assign load_o = load_q;
    assign ctrl_o = ctrl_q;
    assign ris_o  = ris;
    assign mis_o  = ris && ctrl_q.ie;
    assign irq_o  = mis_o;
endmodule

// File: rtl/dctimer_chan_chk.sv
module dctimer_chan_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_load,
    input logic             wr_bgload,
    input logic             wr_ctrl,
    input logic             wr_intclr,
    input logic [CNT_W-1:0] wdata,
    input logic [CNT_W-1:0] value_o,
    input logic [CNT_W-1:0] load_o,
    input logic [7:0]       ctrl_o,
    input logic             ris_o
);
    localparam int HALF_W = CNT_W / 2;

    p_ctrl_wr_r1: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> ctrl_o == ($past(wdata[7:0]) & 8'hEF));

    p_load_wr_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_load && !wr_bgload) |=> (value_o == $past(wdata)) && (load_o == $past(wdata)));

    p_upper_kept_r3: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_o[1] && !wr_load && !wr_ctrl)
            |=> value_o[CNT_W-1:HALF_W] == $past(value_o[CNT_W-1:HALF_W]));

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_o[7] && !wr_load) |=> value_o == $past(value_o));

    p_ris_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (ris_o && !wr_intclr) |=> ris_o);

    p_intclr_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_intclr && !ctrl_o[7]) |=> !ris_o);
endmodule

bind dctimer_chan dctimer_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_load   (wr_load),
    .wr_bgload (wr_bgload),
    .wr_ctrl   (wr_ctrl),
    .wr_intclr (wr_intclr),
    .wdata     (wdata),
    .value_o   (value_o),
    .load_o    (load_o),
    .ctrl_o    (ctrl_o),
    .ris_o     (ris_o)
);

// File: tb/dctimer_chan_bench.sv
module dctimer_chan_bench;
    localparam int S_LOAD = 0, S_BG = 1, S_CTRL = 2, S_CLR = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_load = 1'b0, wr_bgload = 1'b0, wr_ctrl = 1'b0, wr_intclr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] value_o, load_o;
    logic [7:0]  ctrl_o;
    logic ris_o, mis_o, irq_o;
    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    dctimer_chan u_dctimer_chan (
        .clk(clk), .rst(rst), .wr_load(wr_load), .wr_bgload(wr_bgload),
        .wr_ctrl(wr_ctrl), .wr_intclr(wr_intclr), .wdata(wdata),
        .value_o(value_o), .load_o(load_o), .ctrl_o(ctrl_o),
        .ris_o(ris_o), .mis_o(mis_o), .irq_o(irq_o)
    );

    task automatic wr(input int sel, input logic [31:0] d);
        @(negedge clk);
        wdata = d;
        case (sel)
            S_LOAD:  wr_load   = 1'b1;
            S_BG:    wr_bgload = 1'b1;
            S_CTRL:  wr_ctrl   = 1'b1;
            default: wr_intclr = 1'b1;
        endcase
        @(negedge clk);
        wr_load = 1'b0; wr_bgload = 1'b0; wr_ctrl = 1'b0; wr_intclr = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        // R10 reset state
        chk("R10 ctrl", 32'(ctrl_o), 32'h20);
        chk("R10 load", load_o, 32'h0);
        chk("R10 value", value_o, 32'hFFFF_FFFF);
        chk("R10 ris", 32'(ris_o), 32'h0);

        // R1 reserved bit dropped
        wr(S_CTRL, 32'hFFFF_FF5F);
        chk("R1 ctrl readback", 32'(ctrl_o), 32'h4F);
        wr(S_CTRL, 32'h00);

        // R3 R4 R8 16-bit free-run sweep
        wr(S_LOAD, 32'h00AB_0003);
        wr(S_CTRL, 32'h80);
        for (int k = 1; k <= 6; k++) begin
            step(1);
            chk("R3 R4 16b free count", value_o, {16'h00AB, 16'(3 - k)});
            chk("R8 raw flag", 32'(ris_o), (k >= 3) ? 32'h1 : 32'h0);
            chk("R9 masked off", 32'(mis_o), 32'h0);
        end

        // R4 periodic 32-bit sweep, period load+1
        wr(S_CTRL, 32'h02);
        wr(S_CLR, 32'h0);
        chk("R8 clear", 32'(ris_o), 32'h0);
        wr(S_LOAD, 32'd3);
        wr(S_CTRL, 32'hC2);
        for (int k = 1; k <= 9; k++) begin
            step(1);
            chk("R4 periodic count", value_o, 32'(3 - (k % 4)));
        end

        // R6 deferred load
        wr(S_CTRL, 32'h42);
        wr(S_LOAD, 32'd2);
        wr(S_BG, 32'd6);
        chk("R6 bg keeps count", value_o, 32'd2);
        chk("R6 bg stores", load_o, 32'd6);
        wr(S_CTRL, 32'hC2);
        step(2);
        chk("R6 count before reload", value_o, 32'd0);
        step(1);
        chk("R6 reload from bg", value_o, 32'd6);
        step(1);
        chk("R6 after reload", value_o, 32'd5);

        // R7 periodic zero load halts
        wr(S_CLR, 32'h0);
        wr(S_LOAD, 32'd0);
        step(5);
        chk("R7 halted value", value_o, 32'd0);
        chk("R7 no flag", 32'(ris_o), 32'h0);
        wr(S_LOAD, 32'd4);
        step(1);
        chk("R7 resumed", value_o, 32'd3);

        // R5 one-shot
        wr(S_CTRL, 32'h03);
        wr(S_CLR, 32'h0);
        wr(S_LOAD, 32'd2);
        wr(S_CTRL, 32'h83);
        step(2);
        chk("R5 reached zero", value_o, 32'd0);
        chk("R8 set by decrement", 32'(ris_o), 32'h1);
        step(4);
        chk("R5 stays stopped", value_o, 32'd0);
        wr(S_CTRL, 32'h83);
        chk("R5 restart write", value_o, 32'd0);
        step(1);
        chk("R5 wrap after restart", value_o, 32'hFFFF_FFFF);
        step(1);
        chk("R5 counting again", value_o, 32'hFFFF_FFFE);

        // R2 prescale 16
        wr(S_CTRL, 32'h02);
        wr(S_LOAD, 32'd100);
        wr(S_CTRL, 32'h86);
        step(15);
        chk("R2 div16 before", value_o, 32'd100);
        step(1);
        chk("R2 div16 first", value_o, 32'd99);
        step(16);
        chk("R2 div16 second", value_o, 32'd98);

        // R2 prescale code 3 behaves as code 2
        wr(S_CTRL, 32'h02);
        wr(S_LOAD, 32'd100);
        wr(S_CTRL, 32'h8E);
        chk("R1 code3 readback", 32'(ctrl_o), 32'h8E);
        step(255);
        chk("R2 code3 before", value_o, 32'd100);
        step(1);
        chk("R2 code3 first", value_o, 32'd99);
        step(256);
        chk("R2 code3 second", value_o, 32'd98);
        wr(S_CTRL, 32'h02);
        wr(S_LOAD, 32'd100);
        wr(S_CTRL, 32'h8A);
        step(255);
        chk("R2 code2 before", value_o, 32'd100);
        step(1);
        chk("R2 code2 first", value_o, 32'd99);

        // R3 borrow in 32-bit, R4 R8 wrap in 16-bit
        wr(S_CTRL, 32'h02);
        wr(S_LOAD, 32'h0005_0000);
        wr(S_CTRL, 32'h82);
        step(1);
        chk("R3 32b borrow", value_o, 32'h0004_FFFF);
        wr(S_CTRL, 32'h00);
        wr(S_CLR, 32'h0);
        wr(S_LOAD, 32'h0005_0000);
        wr(S_CTRL, 32'h80);
        step(1);
        chk("R3 16b wrap keeps upper", value_o, 32'h0005_FFFF);
        chk("R8 no flag on wrap", 32'(ris_o), 32'h0);
        step(1);
        chk("R3 16b next", value_o, 32'h0005_FFFE);

        // R9 masking
        wr(S_CTRL, 32'h02);
        wr(S_CLR, 32'h0);
        wr(S_LOAD, 32'd1);
        wr(S_CTRL, 32'hA2);
        step(1);
        chk("R9 ris", 32'(ris_o), 32'h1);
        chk("R9 mis on", 32'(mis_o), 32'h1);
        chk("R9 irq on", 32'(irq_o), 32'h1);
        wr(S_CTRL, 32'h82);
        chk("R9 mis masked", 32'(mis_o), 32'h0);
        chk("R9 irq masked", 32'(irq_o), 32'h0);
        chk("R8 sticky", 32'(ris_o), 32'h1);
        wr(S_CTRL, 32'h02);
        wr(S_CLR, 32'h0);
        chk("R8 cleared", 32'(ris_o), 32'h0);

        // R11 disabled holds
        wr(S_LOAD, 32'h1234_5678);
        step(10);
        chk("R11 hold", value_o, 32'h1234_5678);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule